// File: doc/BRIEF.md
# Load-Reserve / Store-Conditional Reservation Monitor

This block keeps the single, system-wide reservation used by atomic read-modify-write sequences built from a reserving load and a conditional store. Every memory access from every requester is shown to the monitor through one request port, one per clock. Each request carries an operation code, a byte address, a transaction size and the requester's ID. The memory, the arbitration between requesters and the instruction decode are outside the block.

A reserving load takes the reservation and tags it with the address, size and ID of the request. A plain store from another requester whose byte range overlaps the reserved range cancels it. A conditional store is answered one cycle later with a status bit: 0 means the store may be written to memory, 1 means it must be dropped. Every conditional store cancels the reservation, whether it passes or fails.

Top module: `resmon_top`

## Requirements
- R1: A synchronous reset leaves the monitor with no reservation, so the first conditional store after reset fails, and no response is issued while reset is held.
- R2: A reserving load with a legal size always takes the reservation and replaces the address, size and owner of any earlier reservation, even one held by another requester.
- R3: A conditional store passes (status 0) only when a reservation is held and its address, size and requester ID are all equal to the reserved ones; a difference in any one of them gives status 1.
- R4: Every conditional store clears the reservation, whatever its address and whether it passed or failed.
- R5: A plain store by a requester other than the owner clears the reservation when its byte range overlaps the reserved one.
- R6: A plain store by the owner, or a plain store whose range is disjoint from the reserved range, leaves the reservation intact.
- R7: Ranges are taken with inclusive ends, [addr, addr+size] and [tag, tag+size]; they are disjoint only when one end is strictly below the other start, so ranges that just touch count as overlapping.
- R8: A plain load never changes the reservation.
- R9: Size codes are byte counts, legal values 1, 2, 4 and 8 (up to 2**MAX_SIZE_LOG2); a conditional store with any other code (including 0) fails and still clears the reservation, and a reserving load or plain store with such a code changes nothing.
- R10: The response strobe is high for exactly one cycle, the cycle after a valid conditional-store request, and never for any other operation or for an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request present this cycle |
| reqOp | input | 2 | Operation: 0 plain load, 1 reserving load, 2 plain store, 3 conditional store |
| reqAddr | input | ADDR_W | Byte address of the access |
| reqSize | input | 4 | Transaction size in bytes |
| reqOwner | input | OWNER_W | Requester ID |
| respValid | output | 1 | Conditional-store status is valid (one-cycle pulse) |
| respFail | output | 1 | Status: 0 pass, 1 fail |

## Verification
The bench drives reserve/conditional-store pairs that differ from the reservation in exactly one of address, size or owner, so each mismatch is told apart from the others. Plain stores are placed just inside, exactly touching and just outside both ends of the reserved range, from the owner and from a stranger, which separates an inclusive-end overlap test from an exclusive one and an owner check from none. Repeated conditional stores, interleaved reserving loads from two owners, plain loads, and illegal size codes on each operation show which requests clear, replace or leave the reservation, and idle cycles with the conditional-store code present but no valid strobe show that responses come only from real requests.

// File: rtl/resmon_pkg.sv
package resmon_pkg;

  typedef enum logic [1:0] {
    OP_LOAD      = 2'd0,
    OP_RESLOAD   = 2'd1,
    OP_STORE     = 2'd2,
    OP_CONDSTORE = 2'd3
  } reqOp_e;

  localparam int SIZE_W = 4;

  // Strobes from control to datapath
  typedef struct packed {
    logic takeTag;
    logic dropTag;
    logic respond;
    logic fail;
  } ctlStrobe_t;

  // Comparison results from datapath to control
  typedef struct packed {
    logic excl;
    logic overlap;
    logic exactMatch;
    logic ownerHit;
  } dpFlags_t;

  // Legal sizes: a single set bit at a power of two up to 2**maxLog2
  function automatic logic sizeLegal(input logic [SIZE_W-1:0] sz, input int maxLog2);
    logic ok;
    ok = 1'b0;
    for (int i = 0; i < SIZE_W; i++) begin
      if (i <= maxLog2 && sz == (SIZE_W'(1) << i)) ok = 1'b1;
    end
    return ok;
  endfunction

endpackage

// File: rtl/resmon_datapath.sv
module resmon_datapath
  import resmon_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OWNER_W = 4,
  parameter int MAX_SIZE_LOG2 = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reqValid,
  input  logic [1:0]         reqOp,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [SIZE_W-1:0]  reqSize,
  input  logic [OWNER_W-1:0] reqOwner,
  input  ctlStrobe_t         strobe,
  output dpFlags_t           flags
);

  localparam int END_W = ADDR_W + 1;

  logic               exclQ;
  logic [ADDR_W-1:0]  tagAddrQ;
  logic [SIZE_W-1:0]  tagSizeQ;
  logic [OWNER_W-1:0] tagOwnerQ;

  logic [END_W-1:0] reqStart, reqEnd, tagStart, tagEnd;
  logic disjoint;

  // Inclusive-end ranges, one extra bit so the end never wraps
  always_comb begin
    reqStart = {1'b0, reqAddr};
    reqEnd   = reqStart + END_W'(reqSize);
    tagStart = {1'b0, tagAddrQ};
    tagEnd   = tagStart + END_W'(tagSizeQ);
    disjoint = (reqEnd < tagStart) || (tagEnd < reqStart);
  end

  always_comb begin
    flags.excl       = exclQ;
    flags.overlap    = !disjoint;
    flags.ownerHit   = (reqOwner == tagOwnerQ);
    flags.exactMatch = (reqAddr == tagAddrQ) && (reqSize == tagSizeQ) &&
                       (reqOwner == tagOwnerQ);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      exclQ     <= 1'b0;
      tagAddrQ  <= '0;
      tagSizeQ  <= '0;
      tagOwnerQ <= '0;
    end else if (strobe.takeTag) begin
      exclQ     <= 1'b1;
      tagAddrQ  <= reqAddr;
      tagSizeQ  <= reqSize;
      tagOwnerQ <= reqOwner;
    end else if (strobe.dropTag) begin
      exclQ     <= 1'b0;
      tagAddrQ  <= '0;
      tagSizeQ  <= '0;
      tagOwnerQ <= '0;
    end
  end

  // R2: a legal reserving load always ends with its own tag in place
  a_r2_resload_takes: assert property (@(posedge clk) disable iff (rst)
    reqValid && reqOp == OP_RESLOAD && sizeLegal(reqSize, MAX_SIZE_LOG2)
    |=> exclQ && tagAddrQ == $past(reqAddr) && tagOwnerQ == $past(reqOwner));

  // R4: any conditional store leaves no reservation
  a_r4_cond_clears: assert property (@(posedge clk) disable iff (rst)
    reqValid && reqOp == OP_CONDSTORE |=> !exclQ);

  // R8: a plain load leaves the reservation untouched
  a_r8_load_inert: assert property (@(posedge clk) disable iff (rst)
    reqValid && reqOp == OP_LOAD |=> $stable(exclQ) && $stable(tagAddrQ) && $stable(tagOwnerQ));

  // R6: the owner's own plain store does not cancel
  a_r6_owner_store_keeps: assert property (@(posedge clk) disable iff (rst)
    reqValid && reqOp == OP_STORE && exclQ && reqOwner == tagOwnerQ |=> exclQ);

  // R9: an illegal size on a non-conditional op changes nothing
  a_r9_bad_size_inert: assert property (@(posedge clk) disable iff (rst)
    reqValid && reqOp != OP_CONDSTORE && !sizeLegal(reqSize, MAX_SIZE_LOG2)
    |=> $stable(exclQ) && $stable(tagAddrQ) && $stable(tagSizeQ));

endmodule

// File: rtl/resmon_control.sv
module resmon_control
  import resmon_pkg::*;
#(
  parameter int MAX_SIZE_LOG2 = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  input  logic [SIZE_W-1:0] reqSize,
  input  dpFlags_t          flags,
  output ctlStrobe_t        strobe,
  output logic              respValid,
  output logic              respFail
);

  reqOp_e op;
  logic   sizeOk;

  always_comb begin
    op     = reqOp_e'(reqOp);
    sizeOk = sizeLegal(reqSize, MAX_SIZE_LOG2);
    strobe = '0;
    if (reqValid) begin
      unique case (op)
        OP_RESLOAD: strobe.takeTag = sizeOk;
        OP_STORE:   strobe.dropTag = sizeOk && flags.excl && flags.overlap && !flags.ownerHit;
        OP_CONDSTORE: begin
          strobe.dropTag = 1'b1;
          strobe.respond = 1'b1;
          strobe.fail    = !(sizeOk && flags.excl && flags.exactMatch);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      respValid <= 1'b0;
      respFail  <= 1'b0;
    end else begin
      respValid <= strobe.respond;
      respFail  <= strobe.respond ? strobe.fail : 1'b0;
    end
  end

  // R3: a pass needs a held reservation in the request cycle
  a_r3_pass_needs_excl: assert property (@(posedge clk) disable iff (rst)
    respValid && !respFail |-> $past(flags.excl) && $past(flags.exactMatch));

  // R10: a response is never two cycles long
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
    respValid && !(reqValid && op == OP_CONDSTORE) |=> !respValid);

endmodule

// File: rtl/resmon_top.sv
module resmon_top
  import resmon_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OWNER_W = 4,
  parameter int MAX_SIZE_LOG2 = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reqValid,
  input  logic [1:0]         reqOp,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [3:0]         reqSize,
  input  logic [OWNER_W-1:0] reqOwner,
  output logic               respValid,
  output logic               respFail
);

  ctlStrobe_t strobe;
  dpFlags_t   flags;

  resmon_datapath #(
    .ADDR_W(ADDR_W), .OWNER_W(OWNER_W), .MAX_SIZE_LOG2(MAX_SIZE_LOG2)
  ) u_dp (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqOwner(reqOwner),
    .strobe(strobe), .flags(flags)
  );

  resmon_control #(
    .MAX_SIZE_LOG2(MAX_SIZE_LOG2)
  ) u_ctl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqOp(reqOp),
    .reqSize(reqSize), .flags(flags), .strobe(strobe),
    .respValid(respValid), .respFail(respFail)
  );

  // R1: no response leaves the block in the cycle after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $past(rst) |-> !respValid);

endmodule

// File: tb/resmon_top_bench.sv
module resmon_top_bench;

  localparam int AW = 32;
  localparam int OW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reqValid = 1'b0;
  logic [1:0]    reqOp = 2'd0;
  logic [AW-1:0] reqAddr = '0;
  logic [3:0]    reqSize = '0;
  logic [OW-1:0] reqOwner = '0;
  logic          respValid, respFail;

  always #2 clk = ~clk;  // 250 MHz

  resmon_top #(.ADDR_W(AW), .OWNER_W(OW)) u_resmon_top (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqOwner(reqOwner), .respValid(respValid), .respFail(respFail)
  );

  int applied = 0;
  int failed  = 0;
  int cyc     = 0;
  bit done    = 0;

  logic  expQ[$];
  int    stampQ[$];
  string tagQ[$];

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare each response with the oldest expected item
  always @(negedge clk) begin
    if (!done) begin
      if (rst) begin
        applied++;
        if (respValid) begin failed++; $display("FAIL R1 respValid during reset act=1 exp=0"); end
      end else if (respValid) begin
        applied++;
        if (expQ.size() == 0) begin
          failed++; $display("FAIL R10 unexpected response act=1 exp=0");
        end else begin
          automatic logic e = expQ.pop_front();
          automatic int   s = stampQ.pop_front();
          automatic string t = tagQ.pop_front();
          if (respFail !== e || cyc != s + 1) begin
            failed++;
            $display("FAIL %s status act=%0b exp=%0b cyc act=%0d exp=%0d", t, respFail, e, cyc, s + 1);
          end
        end
      end else if (expQ.size() != 0 && cyc > stampQ[0] + 1) begin
        applied++; failed++;
        $display("FAIL %s missing response act=0 exp=1", tagQ.pop_front());
        void'(expQ.pop_front()); void'(stampQ.pop_front());
      end
    end
  end

  task automatic issue(input logic [1:0] op, input logic [AW-1:0] a, input logic [3:0] sz,
                       input logic [OW-1:0] own);
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqAddr = a; reqSize = sz; reqOwner = own;
    @(posedge clk);
  endtask

  task automatic rl(input logic [AW-1:0] a, input logic [3:0] sz, input logic [OW-1:0] own);
    issue(2'd1, a, sz, own);
  endtask
  task automatic st(input logic [AW-1:0] a, input logic [3:0] sz, input logic [OW-1:0] own);
    issue(2'd2, a, sz, own);
  endtask
  task automatic ld(input logic [AW-1:0] a, input logic [3:0] sz, input logic [OW-1:0] own);
    issue(2'd0, a, sz, own);
  endtask
  task automatic cs(input logic [AW-1:0] a, input logic [3:0] sz, input logic [OW-1:0] own,
                    input logic expFail, input string t);
    @(negedge clk);
    reqValid = 1'b1; reqOp = 2'd3; reqAddr = a; reqSize = sz; reqOwner = own;
    expQ.push_back(expFail); stampQ.push_back(cyc); tagQ.push_back(t);
    @(posedge clk);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      reqValid = 1'b0; reqOp = 2'd3;
      @(posedge clk);
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    cs(32'h100, 4, 1, 1, "R1");                                  // nothing reserved
    rl(32'h100, 4, 1); cs(32'h100, 4, 1, 0, "R3");               // exact match passes
    cs(32'h100, 4, 1, 1, "R4");                                  // cleared by pass
    rl(32'h100, 4, 1); cs(32'h104, 4, 1, 1, "R3"); cs(32'h100, 4, 1, 1, "R4");
    rl(32'h100, 4, 1); cs(32'h100, 2, 1, 1, "R3");               // size mismatch
    rl(32'h100, 4, 1); cs(32'h100, 4, 2, 1, "R3");               // owner mismatch
    rl(32'h100, 4, 1); rl(32'h100, 4, 2); cs(32'h100, 4, 1, 1, "R2");
    rl(32'h100, 4, 1); rl(32'h140, 2, 2); cs(32'h140, 2, 2, 0, "R2");
    rl(32'h100, 4, 1); st(32'h102, 1, 2); cs(32'h100, 4, 1, 1, "R5");
    rl(32'h100, 4, 1); st(32'h100, 4, 1); cs(32'h100, 4, 1, 0, "R6");
    rl(32'h100, 4, 1); st(32'h200, 4, 2); cs(32'h100, 4, 1, 0, "R6");
    rl(32'h100, 4, 1); st(32'h104, 1, 2); cs(32'h100, 4, 1, 1, "R7");
    rl(32'h100, 4, 1); st(32'h0FC, 4, 2); cs(32'h100, 4, 1, 1, "R7");
    rl(32'h100, 4, 1); st(32'h105, 1, 2); cs(32'h100, 4, 1, 0, "R7");
    rl(32'h100, 4, 1); st(32'h0FB, 4, 2); cs(32'h100, 4, 1, 0, "R7");
    rl(32'h100, 4, 1); ld(32'h100, 4, 2); cs(32'h100, 4, 1, 0, "R8");
    rl(32'h100, 8, 3); cs(32'h100, 8, 3, 0, "R9");
    rl(32'h101, 1, 3); cs(32'h101, 1, 3, 0, "R9");
    rl(32'h102, 2, 3); cs(32'h102, 2, 3, 0, "R9");
    rl(32'h100, 4, 1); rl(32'h300, 3, 2); cs(32'h100, 4, 1, 0, "R9");
    rl(32'h100, 4, 1); st(32'h100, 0, 2); cs(32'h100, 4, 1, 0, "R9");
    rl(32'h100, 0, 1); cs(32'h100, 0, 1, 1, "R9");
    rl(32'h100, 4, 1); cs(32'h100, 5, 1, 1, "R9"); cs(32'h100, 4, 1, 1, "R9");
    idle(3);                                                     // R10: no strobe, no response
    rl(32'h100, 4, 1); idle(2); cs(32'h100, 4, 1, 0, "R10");
    idle(3);

    if (expQ.size() != 0) begin
      applied++; failed++;
      $display("FAIL R10 responses outstanding act=%0d exp=0", expQ.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    done = 1; applied++; failed++;
    $display("FAIL R10 watchdog expired act=hung exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
    $finish;
  end

endmodule